// File: doc/BRIEF.md
# Rate-Feedback IN Endpoint Buffer

This block is the transmit buffer of a single USB IN endpoint. The CPU side loads bytes one at a time and programs a maximum packet size. It sets a packet-ready flag, flushes stale contents, and selects between normal handshaking and a feedback mode. On the bus side, each IN token strobe receives a one-cycle response. The response either announces a data packet of a given length, with the bytes streamed out over the following cycles, or reports a NAK.

In normal mode a packet is sent only once packet-ready is set. The packet stays committed until the host acknowledges it, and the acknowledgement empties the buffer. In feedback mode the endpoint always has something to say. It never NAKs, ignores packet-ready, and rewinds after every transmission, so an unchanged buffer is replayed byte for byte. To update it, the CPU flushes, loads the new status bytes and sets packet-ready. Feedback mode only takes effect when the maximum packet size exceeds half the buffer, so the buffer holds exactly one packet.

The controller has three states. IDLE waits for a token. SEND streams bytes. WAIT_ACK holds a normal-mode packet until the host acknowledges it. The transitions are:
- IDLE→SEND on an accepted token with a non-zero length.
- IDLE→WAIT_ACK on a normal-mode zero-length packet.
- SEND→IDLE after the last byte in feedback mode.
- SEND→WAIT_ACK after the last byte in normal mode.
- WAIT_ACK→IDLE on the host acknowledgement.
- Any state→IDLE on flush.

Top module: `rate_fb_in_ep`

## Requirements
- R1: After reset, pkt_rdy and overrun are 0, no response or byte is presented, the buffer is empty and the maximum packet size equals DEPTH.
- R2: In normal mode with pkt_rdy clear, an IN token yields rsp_valid for exactly one cycle with rsp_nak=1 and rsp_len=0, and no bytes follow.
- R3: In normal mode with pkt_rdy set, the cycle after the token shows rsp_valid with rsp_nak=0 and rsp_len equal to the smaller of the loaded byte count and the maximum packet size. The bytes then appear on rd_data in load order, with rd_valid high for rsp_len consecutive cycles starting in the response cycle.
- R4: After a normal-mode packet, the endpoint waits for tok_ack. That acknowledgement clears pkt_rdy and empties the buffer. Tokens that arrive while a packet is streaming or awaiting acknowledgement get no response.
- R5: A CPU byte write made when the count has reached the maximum packet size is discarded and sets overrun, which stays set until a flush.
- R6: A flush empties the buffer, rewinds both pointers, and clears pkt_rdy and overrun at the next clock edge. It also aborts any transfer in progress, so no further bytes are streamed.
- R7: Feedback behaviour applies only while cpu_fb_mode is 1 and the maximum packet size is greater than DEPTH/2. Otherwise the endpoint behaves as in normal mode.
- R8: In feedback mode every token gets a data response (rsp_nak=0) with the current contents, whatever pkt_rdy says. A transmission leaves pkt_rdy unchanged, and tok_ack has no effect.
- R9: In feedback mode the read pointer rewinds after each transmission, so repeated tokens over an unchanged buffer produce identical packets.
- R10: In feedback mode an empty buffer is answered with a zero-length packet (rsp_nak=0, rsp_len=0).
- R11: A maximum packet size written above DEPTH is stored as DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Load one byte into the buffer |
| cpu_wr_data | input | DW (8) | Byte to load |
| cpu_set_rdy | input | 1 | Set packet-ready |
| cpu_flush | input | 1 | Discard buffer contents |
| cpu_fb_mode | input | 1 | Feedback (interrupt) mode select |
| cpu_maxp_we | input | 1 | Write the maximum packet size |
| cpu_maxp | input | $clog2(DEPTH+1) (5) | New maximum packet size |
| pkt_rdy | output | 1 | Packet-ready flag |
| overrun | output | 1 | Sticky discarded-write flag |
| tok_in | input | 1 | IN token strobe |
| tok_ack | input | 1 | Host acknowledge strobe |
| rsp_valid | output | 1 | One-cycle token response |
| rsp_nak | output | 1 | Response is a NAK |
| rsp_len | output | $clog2(DEPTH+1) (5) | Packet length in bytes |
| rd_valid | output | 1 | Byte present on rd_data |
| rd_data | output | DW (8) | Streamed packet byte |

## Verification
The bench builds the block with DEPTH=16 and DW=8. With these values the feedback threshold of 8 can be crossed by programming a packet size of 8 (mode inert) and then 12 (mode active). A 17-byte load after a size of 20 is written exercises both the clamp to 16 and an overrun at the full buffer. A packet size of 4 lets a six-byte load show truncation while the buffer still has free room.

// File: rtl/rfe_pkg.sv
`timescale 1ns/1ps
package rfe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SEND     = 2'd1,
        ST_WAIT_ACK = 2'd2
    } rfe_state_e;
endpackage

// File: rtl/rfe_store.sv
`timescale 1ns/1ps
module rfe_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rfe_fill.sv
`timescale 1ns/1ps
module rfe_fill #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH+1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          empty_i,   // flush or host acknowledge
    input  logic          flush_i,
    input  logic          maxp_we,
    input  logic [CW-1:0] maxp_in,
    output logic          wr_fire,
    output logic [AW-1:0] wr_addr,
    output logic [CW-1:0] count,
    output logic [CW-1:0] maxp,
    output logic          overrun
);
    logic full_lim;

    assign full_lim = (count >= maxp);
    assign wr_fire  = wr_en && !empty_i && !full_lim;
    assign wr_addr  = count[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            overrun <= 1'b0;
            maxp    <= CW'(DEPTH);
        end else begin
            if (maxp_we)
                maxp <= (maxp_in > CW'(DEPTH)) ? CW'(DEPTH) : maxp_in;
            if (empty_i)
                count <= '0;
            else if (wr_fire)
                count <= count + CW'(1);
            if (flush_i)
                overrun <= 1'b0;
            else if (wr_en && !empty_i && full_lim)
                overrun <= 1'b1;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (count == '0) && !overrun); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !flush_i |=> overrun); // R5
    AST_DROP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !empty_i && full_lim |=> overrun && (count == $past(count))); // R5
    AST_MAXP_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        maxp <= CW'(DEPTH)); // R11
endmodule

// File: rtl/rfe_ctrl.sv
`timescale 1ns/1ps
module rfe_ctrl
    import rfe_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH+1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_in,
    input  logic          tok_ack,
    input  logic          set_rdy,
    input  logic          flush,
    input  logic          fb_mode,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] maxp,
    output logic [AW-1:0] rd_ptr,
    output logic          rsp_valid,
    output logic          rsp_nak,
    output logic [CW-1:0] rsp_len,
    output logic          rd_valid,
    output logic          pkt_rdy,
    output logic          consume
);
    rfe_state_e    state_q, state_d;
    logic [CW-1:0] send_len, remain;
    logic          fb_act, fb_q, accept, last;

    assign fb_act   = fb_mode && (maxp > CW'(DEPTH/2));
    assign send_len = (count < maxp) ? count : maxp;
    assign accept   = (state_q == ST_IDLE) && tok_in && !flush;
    assign last     = (remain == CW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tok_in) begin
                    if (fb_act)
                        state_d = (send_len != '0) ? ST_SEND : ST_IDLE;
                    else if (pkt_rdy)
                        state_d = (send_len != '0) ? ST_SEND : ST_WAIT_ACK;
                end
            end
            ST_SEND:     if (last) state_d = fb_q ? ST_IDLE : ST_WAIT_ACK;
            ST_WAIT_ACK: if (tok_ack) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (flush) state_d = ST_IDLE;
    end

    // outputs
    always_comb begin
        rd_valid = (state_q == ST_SEND);
        consume  = (state_q == ST_WAIT_ACK) && tok_ack && !flush;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_nak   <= 1'b0;
            rsp_len   <= '0;
            remain    <= '0;
            fb_q      <= 1'b0;
            rd_ptr    <= '0;
            pkt_rdy   <= 1'b0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_nak <= !fb_act && !pkt_rdy;
                rsp_len <= (fb_act || pkt_rdy) ? send_len : '0;
                remain  <= send_len;
                fb_q    <= fb_act;
                rd_ptr  <= '0;
            end else if (flush || consume) begin
                rd_ptr <= '0;
            end else if (state_q == ST_SEND) begin
                remain <= remain - CW'(1);
                rd_ptr <= last ? '0 : rd_ptr + AW'(1);
            end
            if (flush || consume) pkt_rdy <= 1'b0;
            else if (set_rdy)     pkt_rdy <= 1'b1;
        end
    end

    AST_NAK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_nak |-> (rsp_len == '0) && (state_q == ST_IDLE)); // R2
    AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_nak && (rsp_len != '0) |-> rd_valid && (rd_ptr == '0)); // R3
    AST_WAIT_HOLDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_ACK) |-> pkt_rdy); // R4
    AST_FB_NEVER_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_nak && $past(fb_act))); // R8
    AST_FB_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == ST_SEND) && (state_q == ST_IDLE) |-> (rd_ptr == '0)); // R9
endmodule

// File: rtl/rate_fb_in_ep.sv
`timescale 1ns/1ps
module rate_fb_in_ep #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH+1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr_en,
    input  logic [DW-1:0] cpu_wr_data,
    input  logic          cpu_set_rdy,
    input  logic          cpu_flush,
    input  logic          cpu_fb_mode,
    input  logic          cpu_maxp_we,
    input  logic [CW-1:0] cpu_maxp,
    output logic          pkt_rdy,
    output logic          overrun,
    input  logic          tok_in,
    input  logic          tok_ack,
    output logic          rsp_valid,
    output logic          rsp_nak,
    output logic [CW-1:0] rsp_len,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic          wr_fire, consume;
    logic [AW-1:0] wr_addr, rd_ptr;
    logic [CW-1:0] count, maxp;

    rfe_fill #(.DEPTH(DEPTH)) u_fill (
        .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr_en),
        .empty_i(cpu_flush || consume), .flush_i(cpu_flush),
        .maxp_we(cpu_maxp_we), .maxp_in(cpu_maxp),
        .wr_fire(wr_fire), .wr_addr(wr_addr), .count(count),
        .maxp(maxp), .overrun(overrun)
    );

    rfe_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .we(wr_fire), .waddr(wr_addr), .wdata(cpu_wr_data),
        .raddr(rd_ptr), .rdata(rd_data)
    );

    rfe_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .tok_ack(tok_ack),
        .set_rdy(cpu_set_rdy), .flush(cpu_flush), .fb_mode(cpu_fb_mode),
        .count(count), .maxp(maxp), .rd_ptr(rd_ptr),
        .rsp_valid(rsp_valid), .rsp_nak(rsp_nak), .rsp_len(rsp_len),
        .rd_valid(rd_valid), .pkt_rdy(pkt_rdy), .consume(consume)
    );
endmodule

// File: tb/tb_rate_fb_in_ep.sv
`timescale 1ns/1ps
module tb_rate_fb_in_ep;
    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int CW    = $clog2(DEPTH+1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cpu_wr_en = 0, cpu_set_rdy = 0, cpu_flush = 0, cpu_fb_mode = 0, cpu_maxp_we = 0;
    logic [DW-1:0] cpu_wr_data = '0;
    logic [CW-1:0] cpu_maxp = '0;
    logic          tok_in = 0, tok_ack = 0;
    logic          pkt_rdy, overrun, rsp_valid, rsp_nak, rd_valid;
    logic [CW-1:0] rsp_len;
    logic [DW-1:0] rd_data;

    rate_fb_in_ep #(.DEPTH(DEPTH), .DW(DW)) dut (.*);

    // reference model
    logic [7:0] mdl[$];
    int  maxp_m = DEPTH;
    bit  rdy_m = 0, ovr_m = 0, wait_m = 0;

    // scoreboard
    logic [9:0] exp_q[$];
    string      tag_q[$];
    int checks = 0, fails = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_item(logic [9:0] got);
        if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected output", int'(got), 0);
        else begin
            logic [9:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(got == e, t, "stream item", int'(got), int'(e));
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) cmp_item({1'b0, rsp_nak, 8'(rsp_len)});
            if (rd_valid)  cmp_item({1'b1, 1'b0, rd_data});
        end
    end

    // driver tasks (called on a falling edge)
    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(logic [7:0] b);
        cpu_wr_en = 1; cpu_wr_data = b;
        @(negedge clk);
        cpu_wr_en = 0;
        if (mdl.size() < maxp_m) mdl.push_back(b); else ovr_m = 1;
    endtask

    task automatic set_rdy();
        cpu_set_rdy = 1; @(negedge clk); cpu_set_rdy = 0;
        rdy_m = 1;
    endtask

    task automatic flush();
        cpu_flush = 1; @(negedge clk); cpu_flush = 0;
        mdl.delete(); rdy_m = 0; ovr_m = 0; wait_m = 0;
    endtask

    task automatic set_maxp(int v);
        cpu_maxp_we = 1; cpu_maxp = CW'(v); @(negedge clk); cpu_maxp_we = 0;
        maxp_m = (v > DEPTH) ? DEPTH : v;
    endtask

    task automatic ack();
        tok_ack = 1; @(negedge clk); tok_ack = 0;
        if (wait_m) begin rdy_m = 0; wait_m = 0; mdl.delete(); end
    endtask

    task automatic push_packet(string tag);
        int len;
        len = (mdl.size() < maxp_m) ? mdl.size() : maxp_m;
        exp_q.push_back({1'b0, 1'b0, 8'(len)}); tag_q.push_back(tag);
        for (int i = 0; i < len; i++) begin
            exp_q.push_back({1'b1, 1'b0, mdl[i]}); tag_q.push_back(tag);
        end
    endtask

    // token: model predicts the response, then the strobe is driven
    task automatic token(string tag, int gap);
        bit fb;
        fb = cpu_fb_mode && (maxp_m > DEPTH/2);
        if (!wait_m) begin
            if (fb) push_packet(tag);
            else if (rdy_m) begin push_packet(tag); wait_m = 1; end
            else begin exp_q.push_back({1'b0, 1'b1, 8'd0}); tag_q.push_back(tag); end
        end
        tok_in = 1; @(negedge clk); tok_in = 0;
        idle(gap);
    endtask

    task automatic chk_state(string tag);
        chk(pkt_rdy == rdy_m, tag, "pkt_rdy", int'(pkt_rdy), int'(rdy_m));
        chk(overrun == ovr_m, tag, "overrun", int'(overrun), int'(ovr_m));
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R4: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        // R1: reset state
        chk(pkt_rdy == 0 && overrun == 0, "R1", "flags in reset", int'({pkt_rdy, overrun}), 0);
        chk(rsp_valid == 0 && rd_valid == 0, "R1", "no output in reset", int'({rsp_valid, rd_valid}), 0);
        rst_n = 1;
        idle(1);

        token("R2", 3);                 // NAK without packet-ready
        chk_state("R2");

        load(8'hA1); load(8'hB2); load(8'hC3);
        set_rdy();
        chk_state("R3");
        token("R3", 6);
        chk_state("R4");                // still ready before acknowledge
        token("R4", 3);                 // ignored while awaiting acknowledge
        ack();
        chk_state("R4");
        set_rdy();
        token("R4", 3);                 // buffer emptied by ack: zero length
        ack();

        for (int i = 0; i < 5; i++) load(8'h50 + 8'(i));
        set_rdy();
        token("R4", 1);
        token("R4", 8);                 // second token mid-stream ignored
        ack();

        set_maxp(4);
        for (int i = 0; i < 6; i++) load(8'h60 + 8'(i));
        chk_state("R5");
        set_rdy();
        token("R5", 6);
        ack();
        chk_state("R5");                // overrun survives acknowledge

        flush();
        chk_state("R6");
        load(8'h71); load(8'h72); load(8'h73);
        set_rdy();
        // token, then flush one cycle later: header and first byte only
        exp_q.push_back({1'b0, 1'b0, 8'd3}); tag_q.push_back("R6");
        exp_q.push_back({1'b1, 1'b0, 8'h71}); tag_q.push_back("R6");
        tok_in = 1; @(negedge clk); tok_in = 0;
        flush();
        idle(4);
        chk_state("R6");
        token("R6", 3);                 // NAK: packet-ready cleared by flush

        set_maxp(12);
        cpu_fb_mode = 1;
        token("R10", 3);                // empty buffer: zero-length packet
        load(8'h81); load(8'h82);
        token("R8", 5);                 // sent without packet-ready
        token("R9", 5);                 // replayed identically
        ack();
        chk_state("R8");
        token("R9", 5);
        flush(); load(8'h91); load(8'h92); load(8'h93); set_rdy();
        token("R8", 6);
        chk_state("R8");                // pkt_rdy left set

        set_maxp(8);                    // threshold not exceeded: normal mode
        token("R7", 6);
        ack();
        token("R7", 3);                 // NAK despite feedback bit

        set_maxp(20);                   // clamps to DEPTH
        flush();
        for (int i = 0; i < 17; i++) load(8'hC0 + 8'(i));
        chk_state("R11");
        token("R11", 20);

        idle(5);
        chk(exp_q.size() == 0, "R3", "expected items left", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule